// File: doc/BRIEF.md
# Dual Down-Counting Timer with Sticky Interrupt Status

This peripheral holds two independent down-counters that software drives through a word-wide register port. Each channel has three registers: a reload value, a control register and a live count view. The control register has a small operation code and a source code. The operation code selects load, hold or run. The source code picks which tick-enable input advances the counter. All tick sources are single-cycle enable pulses in the one clock domain of the block. None of them is a separate clock.

When a running channel receives a tick while its count is zero, it reloads from its reload value and raises an expiry. Each expiry sets a sticky status bit. Software clears status bits by writing ones to a pulse-style acknowledge register. A mask register decides which status bits reach the single interrupt line. Raw and masked status views can both be read. A free-running cycle counter is also readable, so software can take timestamps.

Top module: `tmr_dual_timer`

## Requirements
- R1: After reset, both counts read 0, raw status, masked status and mask read 0, irq is low, and both channels are in hold with the disabled source.
- R2: Addresses are byte offsets. Only word-aligned accesses (bus_addr[1:0] = 0) take effect, and any other access reads 0 and writes nothing. Read data appears on bus_rdata one clock after the read request and stays there until the next read. The reload value is at 0x00 for channel 0 and 0x10 for channel 1. Control is at 0x08 and 0x18, and reads back its 5 bits zero-extended.
- R3: Unmapped aligned offsets read as 0, and writes to them change no state.
- R4: While the operation field (control bits [1:0]) is 0 (load), the count follows the reload value. The count becomes equal to it on the second clock after the control write.
- R5: Operation 1 (hold) and the illegal operation 3 freeze the count, whatever the ticks are doing.
- R6: In operation 2 (run), each selected tick decrements a non-zero count by one. A tick at count 0 reloads the reload value and sets status bit 0 for channel 0, or status bit 1 for channel 1. With reload value D, this gives one expiry every D+1 ticks. The counts are read at 0x04 and 0x14.
- R7: Control bits [4:2] select the source. Code 0 selects ext_tick[channel]. Codes 4 to 7 select rate_tick[0] to rate_tick[3]. Codes 1, 2 and 3 select no source, so the count never advances.
- R8: A write to 0x4C clears each raw status bit that has a 1 in bus_wdata, and 0x4C always reads 0. If an expiry and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R9: Raw status is at 0x50, the mask at 0x48 (bits [1:0]), and masked status at 0x54 (raw AND mask). irq is high exactly when the masked status is non-zero. irq updates on the same clock edge as the status or mask change that causes it.
- R10: The 32-bit time counter at 0x38 is 0 at reset and increases by one every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rate_tick | input | 4 | Internal rate tick enables (source codes 4..7) |
| ext_tick | input | 2 | External tick enable, one per channel (source code 0) |
| irq | output | 1 | Registered interrupt, high while any masked status bit is set |

## Verification
A counter that has slipped by one tick shows up as a wrong count value on the next quiet read. It also moves the expiry by a tick, so the sticky status bit appears early or late. A lost acknowledge, or an expiry that loses to an acknowledge in the same cycle, leaves the raw status and the irq line wrong from the very next edge. A mask decode error shows on irq within one clock of the mask write. Random tick bursts at several densities are compared after each burst against a reference counter kept in the bench. Directed cases cover the collision of an acknowledge with an expiry, the illegal codes and misaligned offsets.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OP_W   = 2;
  localparam int SRC_W  = 3;
  localparam int CTRL_W = OP_W + SRC_W;
  localparam int N_CH   = 2;
  localparam int N_RATE = 4;
  localparam int CH_STRIDE = 16;

  localparam logic [7:0] OFS_RELOAD = 8'h00;
  localparam logic [7:0] OFS_COUNT  = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_TIME   = 8'h38;
  localparam logic [7:0] OFS_MASK   = 8'h48;
  localparam logic [7:0] OFS_ACK    = 8'h4C;
  localparam logic [7:0] OFS_RAW    = 8'h50;
  localparam logic [7:0] OFS_MSKD   = 8'h54;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  localparam logic [SRC_W-1:0] SRC_EXT = 3'd0;
  localparam logic [SRC_W-1:0] SRC_OFF = 3'd1;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reload_we,
  input  logic                ctrl_we,
  input  logic [31:0]         wdata,
  input  logic [N_RATE-1:0]   rate_tick,
  input  logic                ext_tick,
  output logic [CNT_W-1:0]    reload_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [CNT_W-1:0]    count_o,
  output logic                expire_o
);
  logic [CNT_W-1:0]  reload_q, count_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [OP_W-1:0]   op;
  logic [SRC_W-1:0]  src;
  logic              tick;

  assign op  = ctrl_q[OP_W-1:0];
  assign src = ctrl_q[CTRL_W-1:OP_W];

  always_comb begin
    if (src[SRC_W-1])
      tick = rate_tick[src[1:0]];
    else if (src == SRC_EXT)
      tick = ext_tick;
    else
      tick = 1'b0;
  end

  assign expire_o = (op == OP_RUN) && tick && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      ctrl_q   <= {SRC_OFF, OP_HOLD};
      count_q  <= '0;
    end else begin
      if (reload_we) reload_q <= wdata[CNT_W-1:0];
      if (ctrl_we)   ctrl_q   <= wdata[CTRL_W-1:0];
      case (op)
        OP_LOAD: count_q <= reload_q;
        OP_RUN: if (tick) count_q <= (count_q == '0) ? reload_q : count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
  assign count_o  = count_q;

  assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD || op == OP_BAD) |=> $stable(count_q));
  assert_load_tracks_R4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (count_q == $past(reload_q)));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            mask_we,
  input  logic            ack_we,
  input  logic [N_CH-1:0] wdata,
  input  logic [N_CH-1:0] expire,
  output logic [N_CH-1:0] raw_o,
  output logic [N_CH-1:0] mask_o,
  output logic            irq_o
);
  logic [N_CH-1:0] raw_q, mask_q, raw_d, mask_d, clr;
  logic            irq_q;

  assign clr    = ack_we ? wdata : '0;
  assign raw_d  = (raw_q & ~clr) | expire;
  assign mask_d = mask_we ? wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= |(raw_d & mask_d);
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    assert_expire_sets_R6: assert property (@(posedge clk) disable iff (rst)
      expire[i] |=> raw_q[i]);
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
      (ack_we && wdata[i] && !expire[i]) |=> !raw_q[i]);
  end
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == |(raw_q & mask_q)));
endmodule

// File: rtl/tmr_dual_timer.sv
module tmr_dual_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [3:0]        rate_tick,
  input  logic [1:0]        ext_tick,
  output logic              irq
);
  logic              aligned, wr;
  logic [7:0]        ofs;
  logic [N_CH-1:0]   reload_we, ctrl_we, expire, raw, mask;
  logic [CNT_W-1:0]  reload_arr [N_CH];
  logic [CNT_W-1:0]  count_arr  [N_CH];
  logic [CTRL_W-1:0] ctrl_arr   [N_CH];
  logic [TIME_W-1:0] time_q;
  logic [31:0]       rd_mux, rdata_q;

  assign ofs     = 8'(bus_addr);
  assign aligned = (bus_addr[1:0] == 2'b00) && (bus_addr == ADDR_W'(ofs));
  assign wr      = bus_en && bus_we && aligned;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [7:0] BASE = 8'(c * CH_STRIDE);
    assign reload_we[c] = wr && (ofs == BASE + OFS_RELOAD);
    assign ctrl_we[c]   = wr && (ofs == BASE + OFS_CTRL);
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .reload_we(reload_we[c]), .ctrl_we(ctrl_we[c]),
      .wdata(bus_wdata), .rate_tick(rate_tick), .ext_tick(ext_tick[c]),
      .reload_o(reload_arr[c]), .ctrl_o(ctrl_arr[c]), .count_o(count_arr[c]),
      .expire_o(expire[c]));
  end

  tmr_irq_ctrl u_irq (
    .clk(clk), .rst(rst),
    .mask_we(wr && (ofs == OFS_MASK)), .ack_we(wr && (ofs == OFS_ACK)),
    .wdata(bus_wdata[N_CH-1:0]), .expire(expire),
    .raw_o(raw), .mask_o(mask), .irq_o(irq));

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      for (int c = 0; c < N_CH; c++) begin
        if (ofs == 8'(c * CH_STRIDE) + OFS_RELOAD) rd_mux = 32'(reload_arr[c]);
        if (ofs == 8'(c * CH_STRIDE) + OFS_COUNT)  rd_mux = 32'(count_arr[c]);
        if (ofs == 8'(c * CH_STRIDE) + OFS_CTRL)   rd_mux = 32'(ctrl_arr[c]);
      end
      case (ofs)
        OFS_TIME: rd_mux = 32'(time_q);
        OFS_MASK: rd_mux = 32'(mask);
        OFS_RAW:  rd_mux = 32'(raw);
        OFS_MSKD: rd_mux = 32'(raw & mask);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q  <= '0;
      rdata_q <= '0;
    end else begin
      time_q <= time_q + 1'b1;
      if (bus_en && !bus_we) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;

  assert_misaligned_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));
  assert_ack_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && bus_addr == ADDR_W'(OFS_ACK)) |=> (bus_rdata == '0));
  assert_time_steps_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (time_q == $past(time_q) + 1'b1));
  assert_rdata_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> $stable(bus_rdata));
endmodule

// File: tb/tmr_dual_timer_tb.sv
module tmr_dual_timer_tb;
  logic        clk = 0, rst = 1;
  logic        bus_en = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [3:0]  rate_tick = 0;
  logic [1:0]  ext_tick = 0;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rd, t0, t1;
  logic        m_run = 0, m_exp = 0;
  logic [31:0] m_cnt = 0, m_rel = 0;

  tmr_dual_timer u_dut (.clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rate_tick(rate_tick), .ext_tick(ext_tick), .irq(irq));

  always #2 clk = ~clk;

  // reference counter for channel 0, source rate_tick[0]
  always @(posedge clk) begin
    if (m_run && rate_tick[0]) begin
      if (m_cnt == 0) begin m_cnt <= m_rel; m_exp <= 1'b1; end
      else m_cnt <= m_cnt - 1;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rdr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] r, input logic [1:0] e, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rate_tick = r; ext_tick = e;
      @(negedge clk); rate_tick = 0; ext_tick = 0;
    end
  endtask

  function automatic logic [31:0] ctl(input int src, input int op);
    return 32'((src << 2) | op);
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rdr(8'h04, rd); check(rd, 0, "R1 count0");
    rdr(8'h14, rd); check(rd, 0, "R1 count1");
    rdr(8'h50, rd); check(rd, 0, "R1 raw");
    rdr(8'h48, rd); check(rd, 0, "R1 mask");
    rdr(8'h08, rd); check(rd, ctl(1, 1), "R1 ctrl0");
    check(32'(irq), 0, "R1 irq");
    // R2 readback and alignment
    wr(8'h00, 32'h1234_5678); rdr(8'h00, rd); check(rd, 32'h1234_5678, "R2 reload0");
    wr(8'h08, 32'hFFFF_FFF1); rdr(8'h08, rd); check(rd, 32'h11, "R2 ctrl0");
    wr(8'h01, 32'hAA); rdr(8'h00, rd); check(rd, 32'h1234_5678, "R2 misaligned write");
    rdr(8'h01, rd); check(rd, 0, "R2 misaligned read");
    // R3 unmapped
    rdr(8'h20, rd); check(rd, 0, "R3 read 0x20");
    wr(8'h5C, 32'hFFFF_FFFF); rdr(8'h5C, rd); check(rd, 0, "R3 read 0x5C");
    rdr(8'h48, rd); check(rd, 0, "R3 mask untouched");
    // R4 load
    wr(8'h00, 5); wr(8'h08, ctl(4, 0)); rdr(8'h04, rd); check(rd, 5, "R4 load");
    wr(8'h00, 2); rdr(8'h04, rd); check(rd, 2, "R4 load follows reload");
    // R6 run and expiry
    wr(8'h08, ctl(4, 2));
    pulse(4'b0001, 0, 1); rdr(8'h04, rd); check(rd, 1, "R6 decrement");
    pulse(4'b0001, 0, 2); rdr(8'h04, rd); check(rd, 2, "R6 reload on expiry");
    rdr(8'h50, rd); check(rd, 1, "R6 status bit0");
    check(32'(irq), 0, "R9 irq masked off");
    rdr(8'h54, rd); check(rd, 0, "R9 masked view 0");
    // R5 hold
    wr(8'h08, ctl(4, 1)); pulse(4'b1111, 2'b11, 2);
    rdr(8'h04, rd); check(rd, 2, "R5 hold frozen");
    // R9 mask
    wr(8'h48, 1); check(32'(irq), 1, "R9 irq on mask write");
    rdr(8'h54, rd); check(rd, 1, "R9 masked view");
    // R8 acknowledge
    wr(8'h4C, 2); rdr(8'h50, rd); check(rd, 1, "R8 other bit ack");
    rdr(8'h4C, rd); check(rd, 0, "R8 ack reads 0");
    wr(8'h4C, 1); rdr(8'h50, rd); check(rd, 0, "R8 ack clears");
    check(32'(irq), 0, "R9 irq drops on ack");
    // R8 collision: expiry and ack same cycle
    wr(8'h00, 1); wr(8'h08, ctl(4, 0)); wr(8'h08, ctl(4, 2));
    pulse(4'b0001, 0, 1); rdr(8'h04, rd); check(rd, 0, "R8 pre count");
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = 8'h4C; bus_wdata = 1; rate_tick = 1;
    @(negedge clk); bus_en = 0; bus_we = 0; rate_tick = 0;
    rdr(8'h50, rd); check(rd, 1, "R8 expiry wins");
    check(32'(irq), 1, "R9 irq after race");
    wr(8'h4C, 1); wr(8'h08, ctl(4, 1));
    // R7 sources on channel 1
    wr(8'h10, 9); wr(8'h18, ctl(4, 0)); wr(8'h18, ctl(4, 3));
    pulse(4'b0001, 0, 2); rdr(8'h14, rd); check(rd, 9, "R5 illegal op holds");
    wr(8'h18, ctl(1, 2)); pulse(4'b1111, 2'b11, 2);
    rdr(8'h14, rd); check(rd, 9, "R7 disabled source");
    wr(8'h18, ctl(2, 2)); pulse(4'b1111, 2'b11, 1);
    rdr(8'h14, rd); check(rd, 9, "R7 invalid source");
    wr(8'h18, ctl(0, 2)); pulse(0, 2'b10, 2); pulse(4'b1111, 2'b01, 1);
    rdr(8'h14, rd); check(rd, 7, "R7 external tick");
    wr(8'h18, ctl(7, 2)); pulse(4'b1000, 0, 1); pulse(4'b0111, 2'b11, 1);
    rdr(8'h14, rd); check(rd, 6, "R7 rate 3");
    wr(8'h18, ctl(1, 1));
    // R10 time
    rdr(8'h38, t0); rdr(8'h38, t1); check(t1 - t0, 2, "R10 time step");
    // R6 random bursts
    wr(8'h4C, 3);
    for (int it = 0; it < 24; it++) begin
      int d, thr, len;
      d = $urandom_range(0, 7); thr = $urandom_range(1, 3); len = $urandom_range(5, 40);
      wr(8'h00, 32'(d)); wr(8'h08, ctl(4, 0)); wr(8'h08, ctl(4, 2));
      m_rel = 32'(d); m_cnt = 32'(d); m_exp = 0; m_run = 1;
      for (int c = 0; c < len; c++) begin
        @(negedge clk); rate_tick = {3'b000, ($urandom % 4) < 32'(thr)};
      end
      @(negedge clk); rate_tick = 0;
      rdr(8'h04, rd); check(rd, m_cnt, "R6 random count");
      rdr(8'h50, rd); check(rd & 1, 32'(m_exp), "R6 random expiry");
      m_run = 0;
      wr(8'h4C, 1); wr(8'h08, ctl(4, 1));
    end
    summary();
  end
endmodule